// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block turns a set of external and internal signal lines into per-line interrupt requests and wake-event pulses. Sixteen lines are fed from general-purpose I/O pins: for every one of them a port selector picks which port's pin of the same number drives the line. A further set of internal lines is edge-configurable in the same way, and a last set of direct lines carries a level that is only masked, never latched.

Every line first passes a two-flop synchroniser and is then compared with its previous synchronised value to find rising and falling edges. On configurable lines, an edge whose trigger is enabled latches into one of two pending registers, one for rising and one for falling edges. Software clears a pending bit by writing 1 to it, and can fire a line through a software-trigger register. Interrupt masking and event masking are independent, so a line can raise an interrupt, a wake event, both, or neither. Software reaches all configuration through a simple word-addressed register port: address, write data and write strobe, with combinational read data.

Top module: `exti_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every configuration and pending register reads 0 and irq_o and evt_o are all low.
- R2: On a configurable line whose rising trigger bit (address 0) is set, a 0-to-1 change of the selected input that is present at clock edge n sets the line's bit in the rising-pending register (address 3) at edge n+2; no earlier edge shows it.
- R3: A 1-to-0 change on a configurable line with its falling trigger bit (address 1) set sets its bit in the falling-pending register (address 4) with the same latency; an edge whose trigger bit is clear sets no pending bit.
- R4: Writing a 1 to a bit at address 3 or 4 clears that pending bit and writing 0 leaves it alone; when a clear and a new set of the same bit meet in one cycle, the bit ends set.
- R5: Writing 1 to a configurable line's bit at address 2 sets its rising-pending bit at the edge that samples the write, as a detected rising edge would; address 2 always reads 0.
- R6: For a configurable line, irq_o is high while its interrupt mask bit (address 5) is 1 and either pending bit is 1; for a direct line it is the mask ANDed with the synchronised input level.
- R7: evt_o of a line pulses high for one cycle, one clock after the edge is seen (or the software write is sampled), when its event mask bit (address 6) is 1; a configurable line pulses on enabled edges and software triggers regardless of pending state, a direct line pulses on each rising edge of its level.
- R8: The port select of GPIO line i is a 2-bit field in the register at address 8 + i/4, at bit 8*(i mod 4); line i is driven by gpio_in[sel*16 + i].
- R9: Direct lines (the top two line indices, 18 and 19) have no trigger, software or pending bits: writes there are ignored and those bit positions read 0.
- R10: Trigger, mask and port-select fields read back what was last written; addresses 7 and 12 to 15 and all bits beyond the defined fields read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | N_PORTS*N_GPIO (64) | Pins of all ports, port p pin i at bit p*N_GPIO+i |
| int_in | input | N_INT (2) | Internal edge-configurable lines 16 and up |
| dir_in | input | N_DIR (2) | Direct level lines, the highest line indices |
| bus_addr | input | ADDR_W (4) | Word address of the register port |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq_o | output | N_LINES (20) | Per-line interrupt request |
| evt_o | output | N_LINES (20) | Per-line wake-event pulse |

## Verification
The bench builds the block with its defaults: sixteen GPIO lines over four ports, two internal configurable lines and two direct lines. With four ports the 2-bit selector has no unused code, so every select value routes a live pin, and the line set straddles both the GPIO-to-internal and the configurable-to-direct boundaries, which puts the ignored bit positions of R9 inside a 32-bit register. Directed sequences pin down the two-cycle pending latency, clear/set collisions and software triggers, and a long random phase of pin toggles and register writes is checked against the reference model every cycle.

// File: rtl/exti_pkg.sv
package exti_pkg;
  // Register word addresses
  localparam int REG_RISE_EN   = 0;
  localparam int REG_FALL_EN   = 1;
  localparam int REG_SW_TRIG   = 2;
  localparam int REG_RISE_PEND = 3;
  localparam int REG_FALL_PEND = 4;
  localparam int REG_IRQ_MASK  = 5;
  localparam int REG_EVT_MASK  = 6;
  localparam int REG_PSEL_BASE = 8;

  // Port-select field packing: four fields per word, 8-bit stride
  localparam int PSEL_PER_REG  = 4;
  localparam int PSEL_STRIDE   = 8;

  function automatic int psel_reg(input int line);
    return REG_PSEL_BASE + line / PSEL_PER_REG;
  endfunction

  function automatic int psel_lsb(input int line);
    return (line % PSEL_PER_REG) * PSEL_STRIDE;
  endfunction
endpackage

// File: rtl/exti_port_mux.sv
module exti_port_mux #(
  parameter int N_GPIO  = 16,
  parameter int N_PORTS = 4,
  parameter int PSEL_W  = 2
) (
  input  logic [N_PORTS*N_GPIO-1:0] gpio_in,
  input  logic [N_GPIO*PSEL_W-1:0]  psel,
  output logic [N_GPIO-1:0]         line_raw
);
  localparam int N_CODES = 1 << PSEL_W;

  for (genvar i = 0; i < N_GPIO; i++) begin : g_line
    logic [N_CODES-1:0] cand;
    for (genvar p = 0; p < N_CODES; p++) begin : g_port
      if (p < N_PORTS) begin : g_live
        assign cand[p] = gpio_in[p*N_GPIO + i];
      end else begin : g_void
        assign cand[p] = 1'b0;
      end
    end
    assign line_raw[i] = cand[psel[i*PSEL_W +: PSEL_W]];
  end
endmodule

// File: rtl/exti_edge.sv
module exti_edge #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level = sync_q;
  assign rise  = sync_q & ~prev_q;
  assign fall  = ~sync_q & prev_q;
endmodule

// File: rtl/exti_regs.sv
module exti_regs
  import exti_pkg::*;
#(
  parameter int N_GPIO  = 16,
  parameter int N_CFG   = 18,
  parameter int N_LINES = 20,
  parameter int PSEL_W  = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_we,
  input  logic [N_CFG-1:0]         rp_i,
  input  logic [N_CFG-1:0]         fp_i,
  output logic [N_CFG-1:0]         rise_en_o,
  output logic [N_CFG-1:0]         fall_en_o,
  output logic [N_LINES-1:0]       imask_o,
  output logic [N_LINES-1:0]       emask_o,
  output logic [N_CFG-1:0]         sw_o,
  output logic [N_CFG-1:0]         rp_clr_o,
  output logic [N_CFG-1:0]         fp_clr_o,
  output logic [N_GPIO*PSEL_W-1:0] psel_o,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int N_ADR = 1 << ADDR_W;

  logic [N_ADR-1:0] wsel;
  always_comb begin
    wsel = '0;
    if (bus_we) wsel[bus_addr] = 1'b1;
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // Trigger enables and masks: next state, enables, registers
  logic [N_CFG-1:0]   ren_q, ren_d, fen_q, fen_d;
  logic [N_LINES-1:0] im_q, im_d, em_q, em_d;
  logic               ren_en, fen_en, im_en, em_en;

  always_comb begin
    ren_en = wsel[REG_RISE_EN];
    fen_en = wsel[REG_FALL_EN];
    im_en  = wsel[REG_IRQ_MASK];
    em_en  = wsel[REG_EVT_MASK];
    ren_d  = bus_wdata[N_CFG-1:0];
    fen_d  = bus_wdata[N_CFG-1:0];
    im_d   = bus_wdata[N_LINES-1:0];
    em_d   = bus_wdata[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ren_q <= '0;
      fen_q <= '0;
      im_q  <= '0;
      em_q  <= '0;
    end else begin
      if (ren_en) ren_q <= ren_d;
      if (fen_en) fen_q <= fen_d;
      if (im_en)  im_q  <= im_d;
      if (em_en)  em_q  <= em_d;
    end
  end

  // Port-select fields, one register per GPIO line
  for (genvar i = 0; i < N_GPIO; i++) begin : g_psel
    logic [PSEL_W-1:0] sel_q, sel_d;
    logic              sel_en;
    always_comb begin
      sel_en = wsel[psel_reg(i)];
      sel_d  = bus_wdata[psel_lsb(i) +: PSEL_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sel_q <= '0;
      else if (sel_en) sel_q <= sel_d;
    end
    assign psel_o[i*PSEL_W +: PSEL_W] = sel_q;
  end

  // Write strobes that act on the pending logic
  always_comb begin
    sw_o     = wsel[REG_SW_TRIG]   ? bus_wdata[N_CFG-1:0] : '0;
    rp_clr_o = wsel[REG_RISE_PEND] ? bus_wdata[N_CFG-1:0] : '0;
    fp_clr_o = wsel[REG_FALL_PEND] ? bus_wdata[N_CFG-1:0] : '0;
  end

  assign rise_en_o = ren_q;
  assign fall_en_o = fen_q;
  assign imask_o   = im_q;
  assign emask_o   = em_q;

  // Read path
  always_comb begin
    rdata_o = '0;
    if (bus_addr == ADDR_W'(REG_RISE_EN))   rdata_o[N_CFG-1:0]   = ren_q;
    if (bus_addr == ADDR_W'(REG_FALL_EN))   rdata_o[N_CFG-1:0]   = fen_q;
    if (bus_addr == ADDR_W'(REG_RISE_PEND)) rdata_o[N_CFG-1:0]   = rp_i;
    if (bus_addr == ADDR_W'(REG_FALL_PEND)) rdata_o[N_CFG-1:0]   = fp_i;
    if (bus_addr == ADDR_W'(REG_IRQ_MASK))  rdata_o[N_LINES-1:0] = im_q;
    if (bus_addr == ADDR_W'(REG_EVT_MASK))  rdata_o[N_LINES-1:0] = em_q;
    for (int i = 0; i < N_GPIO; i++) begin
      if (bus_addr == ADDR_W'(psel_reg(i)))
        rdata_o[psel_lsb(i) +: PSEL_W] = psel_o[i*PSEL_W +: PSEL_W];
    end
  end
endmodule

// File: rtl/exti_pend.sv
module exti_pend #(
  parameter int N_CFG   = 18,
  parameter int N_LINES = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] rise,
  input  logic [N_LINES-1:0] fall,
  input  logic [N_LINES-1:0] level,
  input  logic [N_CFG-1:0]   rise_en,
  input  logic [N_CFG-1:0]   fall_en,
  input  logic [N_LINES-1:0] imask,
  input  logic [N_LINES-1:0] emask,
  input  logic [N_CFG-1:0]   sw,
  input  logic [N_CFG-1:0]   rp_clr,
  input  logic [N_CFG-1:0]   fp_clr,
  output logic [N_CFG-1:0]   rp_o,
  output logic [N_CFG-1:0]   fp_o,
  output logic [N_CFG-1:0]   rset_o,
  output logic [N_CFG-1:0]   fset_o,
  output logic [N_LINES-1:0] irq_o,
  output logic [N_LINES-1:0] evt_o
);
  localparam int N_DIR = N_LINES - N_CFG;

  logic [N_CFG-1:0]   rp_q, rp_d, fp_q, fp_d;
  logic [N_LINES-1:0] evt_q, evt_d;

  logic unused_sig;
  assign unused_sig = ^{fall[N_LINES-1:N_CFG], level[N_CFG-1:0]};

  // Set terms: enabled edges, plus software trigger on the rising side
  always_comb begin
    rset_o = (rise[N_CFG-1:0] & rise_en) | sw;
    fset_o = fall[N_CFG-1:0] & fall_en;
  end

  // Next state: set has priority over a same-cycle clear
  always_comb begin
    rp_d = (rp_q & ~rp_clr) | rset_o;
    fp_d = (fp_q & ~fp_clr) | fset_o;
    evt_d[N_CFG-1:0] = emask[N_CFG-1:0] & (rset_o | fset_o);
    evt_d[N_LINES-1:N_CFG] = emask[N_LINES-1:N_CFG] & rise[N_LINES-1:N_CFG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      fp_q  <= '0;
      evt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      fp_q  <= fp_d;
      evt_q <= evt_d;
    end
  end

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    assign irq_o[N_CFG+d] = imask[N_CFG+d] & level[N_CFG+d];
  end
  assign irq_o[N_CFG-1:0] = imask[N_CFG-1:0] & (rp_q | fp_q);

  assign rp_o  = rp_q;
  assign fp_o  = fp_q;
  assign evt_o = evt_q;
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl #(
  parameter int N_GPIO  = 16,
  parameter int N_PORTS = 4,
  parameter int N_INT   = 2,
  parameter int N_DIR   = 2,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input  logic [0:0]                  clk,
  input  logic                        rst_n,
  input  logic [N_PORTS*N_GPIO-1:0]   gpio_in,
  input  logic [N_INT-1:0]            int_in,
  input  logic [N_DIR-1:0]            dir_in,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [N_GPIO+N_INT+N_DIR-1:0] irq_o,
  output logic [N_GPIO+N_INT+N_DIR-1:0] evt_o
);
  localparam int PSEL_W  = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam int N_CFG   = N_GPIO + N_INT;
  localparam int N_LINES = N_CFG + N_DIR;

  logic [N_GPIO*PSEL_W-1:0] psel;
  logic [N_GPIO-1:0]        gpio_line;
  logic [N_LINES-1:0]       line_raw, level, rise, fall;
  logic [N_LINES-1:0]       imask, emask;
  logic [N_CFG-1:0]         rise_en, fall_en, sw, rp_clr, fp_clr;
  logic [N_CFG-1:0]         rise_pend, fall_pend, rise_set, fall_set;

  exti_port_mux #(.N_GPIO(N_GPIO), .N_PORTS(N_PORTS), .PSEL_W(PSEL_W)) u_mux (
    .gpio_in  (gpio_in),
    .psel     (psel),
    .line_raw (gpio_line)
  );

  assign line_raw = {dir_in, int_in, gpio_line};

  exti_edge #(.W(N_LINES)) u_edge (
    .clk   (clk[0]),
    .rst_n (rst_n),
    .din   (line_raw),
    .level (level),
    .rise  (rise),
    .fall  (fall)
  );

  exti_regs #(
    .N_GPIO(N_GPIO), .N_CFG(N_CFG), .N_LINES(N_LINES),
    .PSEL_W(PSEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk[0]),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .rp_i      (rise_pend),
    .fp_i      (fall_pend),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en),
    .imask_o   (imask),
    .emask_o   (emask),
    .sw_o      (sw),
    .rp_clr_o  (rp_clr),
    .fp_clr_o  (fp_clr),
    .psel_o    (psel),
    .rdata_o   (bus_rdata)
  );

  exti_pend #(.N_CFG(N_CFG), .N_LINES(N_LINES)) u_pend (
    .clk     (clk[0]),
    .rst_n   (rst_n),
    .rise    (rise),
    .fall    (fall),
    .level   (level),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .imask   (imask),
    .emask   (emask),
    .sw      (sw),
    .rp_clr  (rp_clr),
    .fp_clr  (fp_clr),
    .rp_o    (rise_pend),
    .fp_o    (fall_pend),
    .rset_o  (rise_set),
    .fset_o  (fall_set),
    .irq_o   (irq_o),
    .evt_o   (evt_o)
  );
endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk
  import exti_pkg::*;
#(
  parameter int N_CFG   = 18,
  parameter int N_LINES = 20,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [N_LINES-1:0] irq_o,
  input logic [N_LINES-1:0] evt_o,
  input logic [N_CFG-1:0]   rp,
  input logic [N_CFG-1:0]   rset
);
  logic unused_chk;
  assign unused_chk = ^{bus_rdata[N_CFG-1:0], bus_wdata[DATA_W-1:N_CFG]};

  // R1: outputs quiet while held in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (irq_o == '0 && evt_o == '0)
        else $error("outputs active during reset");
    end
  end

  // R2: a rising-pending bit only appears when the edge logic set it
  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rp & ~$past(rp) & ~$past(rset)) == '0);

  // R4: written-one bits clear unless a set met them in the same cycle
  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(REG_RISE_PEND)) |=>
      ((rp & $past(bus_wdata[N_CFG-1:0]) & ~$past(rset)) == '0));

  // R5: a software trigger leaves the rising-pending bits set
  assert_sw_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(REG_SW_TRIG)) |=>
      ((rp & $past(bus_wdata[N_CFG-1:0])) == $past(bus_wdata[N_CFG-1:0])));

  // R7: a direct-line event never lasts two cycles
  assert_dir_evt_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o[N_LINES-1:N_CFG] & $past(evt_o[N_LINES-1:N_CFG])) == '0);

  // R9: direct-line positions of the pending register read 0
  assert_dir_pend_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(REG_RISE_PEND)) |-> (bus_rdata[DATA_W-1:N_CFG] == '0));
endmodule

bind exti_ctrl exti_ctrl_chk #(
  .N_CFG(N_CFG), .N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk[0]),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .evt_o     (evt_o),
  .rp        (rise_pend),
  .rset      (rise_set)
);

// File: tb/exti_ctrl_tb.sv
`timescale 1ns/1ps
module exti_ctrl_tb;
  localparam int NG = 16, NP = 4, NI = 2, ND = 2;
  localparam int NC = NG + NI, NL = NC + ND;

  logic [0:0]       clk;
  logic             rst_n;
  logic [NP*NG-1:0] gpio_in;
  logic [NI-1:0]    int_in;
  logic [ND-1:0]    dir_in;
  logic [3:0]       bus_addr;
  logic [31:0]      bus_wdata;
  logic             bus_we;
  logic [31:0]      bus_rdata;
  logic [NL-1:0]    irq_o, evt_o;

  int n_chk = 0;
  int n_fail = 0;

  exti_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .int_in(int_in), .dir_in(dir_in),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .evt_o(evt_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [NL-1:0] m_s1, m_s2, m_prev, m_im, m_em, m_evt;
  logic [NC-1:0] m_ren, m_fen, m_rp, m_fp;
  int            m_psel [NG];

  function automatic logic [NL-1:0] raw_lines();
    logic [NL-1:0] v;
    for (int i = 0; i < NG; i++) v[i] = gpio_in[m_psel[i]*NG + i];
    for (int k = 0; k < NI; k++) v[NG+k] = int_in[k];
    for (int k = 0; k < ND; k++) v[NC+k] = dir_in[k];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_im = '0; m_em = '0; m_evt = '0;
      m_ren = '0; m_fen = '0; m_rp = '0; m_fp = '0;
      for (int i = 0; i < NG; i++) m_psel[i] = 0;
    end else begin
      logic [NL-1:0] r, f, raw;
      logic [NC-1:0] sw, rs, fs, rc, fc;
      raw = raw_lines();
      r  = m_s2 & ~m_prev;
      f  = ~m_s2 & m_prev;
      sw = (bus_we && bus_addr == 4'd2) ? bus_wdata[NC-1:0] : '0;
      rc = (bus_we && bus_addr == 4'd3) ? bus_wdata[NC-1:0] : '0;
      fc = (bus_we && bus_addr == 4'd4) ? bus_wdata[NC-1:0] : '0;
      rs = (r[NC-1:0] & m_ren) | sw;
      fs = f[NC-1:0] & m_fen;
      m_evt = {m_em[NL-1:NC] & r[NL-1:NC], m_em[NC-1:0] & (rs | fs)};
      m_rp = (m_rp & ~rc) | rs;
      m_fp = (m_fp & ~fc) | fs;
      if (bus_we) begin
        case (bus_addr)
          4'd0: m_ren = bus_wdata[NC-1:0];
          4'd1: m_fen = bus_wdata[NC-1:0];
          4'd5: m_im  = bus_wdata[NL-1:0];
          4'd6: m_em  = bus_wdata[NL-1:0];
          4'd8, 4'd9, 4'd10, 4'd11:
            for (int j = 0; j < 4; j++)
              m_psel[(int'(bus_addr) - 8)*4 + j] = int'(bus_wdata[j*8 +: 2]);
          default: ;
        endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = raw;
    end
  end

  function automatic logic [31:0] model_reg(input int a);
    logic [31:0] v;
    v = '0;
    case (a)
      0: v[NC-1:0] = m_ren;
      1: v[NC-1:0] = m_fen;
      3: v[NC-1:0] = m_rp;
      4: v[NC-1:0] = m_fp;
      5: v[NL-1:0] = m_im;
      6: v[NL-1:0] = m_em;
      8, 9, 10, 11:
        for (int j = 0; j < 4; j++) v[j*8 +: 2] = 2'(m_psel[(a-8)*4 + j]);
      default: ;
    endcase
    return v;
  endfunction

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison of the outputs (R6, R7)
  always @(negedge clk) begin
    logic [NL-1:0] e_irq;
    e_irq = {m_im[NL-1:NC] & m_s2[NL-1:NC], m_im[NC-1:0] & (m_rp | m_fp)};
    check(irq_o === e_irq, "R6 irq_o", 32'(irq_o), 32'(e_irq));
    check(evt_o === m_evt, "R7 evt_o", 32'(evt_o), 32'(m_evt));
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_mod(input int a, input string tag);
    bus_addr = 4'(a);
    #1;
    check(bus_rdata === model_reg(a), tag, bus_rdata, model_reg(a));
  endtask

  task automatic rd_lit(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = 4'(a);
    #1;
    check(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; gpio_in = '0; int_in = '0; dir_in = '0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 16; a++) rd_lit(a, 32'h0, "R1 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) rd_lit(a, 32'h0, "R1 after reset");

    // R2 latency on line 0 with rising trigger only
    wr(0, 32'h0000_0001);
    wr(5, 32'h000F_FFFF);
    @(negedge clk); gpio_in[0] = 1'b1;
    rd_lit(3, 32'h0, "R2 not yet after first edge");
    rd_lit(3, 32'h0, "R2 not yet after second edge");
    rd_lit(3, 32'h1, "R2 set after third edge");
    // R3: falling on line 0 with falling trigger disabled sets nothing
    gpio_in[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd_lit(4, 32'h0, "R3 disabled trigger");
    wr(1, 32'h0000_0003);
    gpio_in[1] = 1'b1; repeat (4) @(negedge clk);
    gpio_in[1] = 1'b0; repeat (4) @(negedge clk);
    rd_lit(4, 32'h2, "R3 falling pending");

    // R4: write 0 leaves, write 1 clears
    wr(3, 32'h0000_0000);
    rd_lit(3, 32'h1, "R4 write 0 keeps");
    wr(3, 32'h0000_0001);
    rd_lit(3, 32'h0, "R4 write 1 clears");
    // R4: clear sampled at the same edge that sets the bit
    @(negedge clk); gpio_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 4'd3; bus_wdata = 32'h1; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd_lit(3, 32'h1, "R4 set wins over clear");
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);

    // R5: software trigger, with event mask on
    wr(6, 32'h000F_FFFF);
    wr(2, 32'h0002_0010);
    rd_lit(2, 32'h0, "R5 sw reads zero");
    rd_lit(3, 32'h0002_0010, "R5 sw sets rising pending");
    wr(3, 32'hFFFF_FFFF);

    // R8: port selection
    wr(8,  32'h0003_0201);
    wr(11, 32'h0100_0302);
    for (int a = 8; a < 12; a++) begin @(negedge clk); rd_mod(a, "R8 R10 psel readback"); end
    wr(0, 32'h0003_FFFF); wr(1, 32'h0003_FFFF);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); gpio_in = {$urandom, $urandom};
      repeat (4) @(negedge clk);
      rd_mod(3, "R8 rising via selected port");
      rd_mod(4, "R8 falling via selected port");
    end

    // R9: direct lines ignore trigger, sw and pending bits
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    rd_lit(0, 32'h0003_FFFF, "R9 R10 rise enable width");
    rd_lit(1, 32'h0003_FFFF, "R9 fall enable width");
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    wr(2, 32'h000C_0000);
    rd_lit(3, 32'h0, "R9 sw on direct lines ignored");
    @(negedge clk); dir_in = 2'b11;
    repeat (4) @(negedge clk);
    rd_lit(3, 32'h0, "R9 direct edge sets no pending");
    dir_in = 2'b00;
    rd_lit(7, 32'h0, "R10 unused address");
    rd_lit(5, 32'h000F_FFFF, "R10 irq mask readback");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if ($urandom % 3 == 0) gpio_in = {$urandom, $urandom};
      if ($urandom % 4 == 0) int_in = 2'($urandom);
      if ($urandom % 4 == 0) dir_in = 2'($urandom);
      bus_we = ($urandom % 5 == 0);
      bus_addr = 4'($urandom % 13);
      bus_wdata = $urandom;
      if (!bus_we) begin
        #1;
        check(bus_rdata === model_reg(int'(bus_addr)), "R10 random readback",
              bus_rdata, model_reg(int'(bus_addr)));
      end
    end
    @(negedge clk); bus_we = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule